// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block is the status and control register that sits beside a floating-point datapath. Each time an arithmetic operation completes, the datapath presents five exception conditions: invalid, divide-by-zero, overflow, underflow and inexact. The register replaces its flag field with exactly the conditions of that operation. It then accumulates them into a sticky cause field. If any accumulated cause has its enable bit set by software, it raises a one-cycle trap request that carries a fixed exception code.

Software loads the register through a write port that drops every bit outside the defined fields. A write also latches two control outputs: a rounding selection (toward zero, or nearest-even) and a flush-denormals-to-zero control. A floating-point compare is reported on the same interface. An unordered compare updates the status fields like any other operation and keeps the true/false bit. An ordered compare writes that bit and leaves the status fields alone.

Top module: `fp_status_reg`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the register reads 0, the rounding output selects nearest-even (0), the flush output is 0, the trap request is 0 and the compare bit is 0.
- R2: A write (wr_en high) stores wr_data AND 0x0005FFFF, readable on csr_q one cycle later. The field layout is: rounding mode [1:0], flags [6:2], enables [11:7], causes [16:12], denormal mode [18].
- R3: On a write, round_to_zero becomes 1 when wr_data[1:0] is 2'b01, and becomes 0 for any other encoding.
- R4: On a write, flush_denorm takes the value of wr_data[18].
- R5: On an update event (op_done, or a compare reported as unordered) without a write, the flag field [6:2] is replaced by op_flags. op_flags[0] is inexact, [1] underflow, [2] overflow, [3] divide-by-zero and [4] invalid, and op_flags[k] lands in bit 2+k.
- R6: On an update event without a write, the cause field [16:12] becomes its old value ORed with op_flags, in the same bit order.
- R7: The cycle after an update event without a write, trap_req is high for one cycle, with trap_code 0x120, exactly when op_flags is nonzero and the new cause field ANDed with the enable field [11:7] is nonzero. Otherwise trap_req is 0 and trap_code is 0.
- R8: An update event with op_flags all zero clears the flag field, keeps the cause field and raises no trap, even when cause and enable bits overlap.
- R9: A compare with cmp_unordered high keeps cmp_bit unchanged. A compare with cmp_unordered low loads cmp_result into cmp_bit and leaves csr_q unchanged.
- R10: When a write and an update event fall in the same cycle, only the write takes effect and no trap is raised.
- R11: round_to_zero and flush_denorm change only on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Arithmetic operation completed this cycle |
| op_flags | input | 5 | Conditions of the operation or unordered compare |
| cmp_valid | input | 1 | Compare completed this cycle |
| cmp_unordered | input | 1 | Compare result was unordered |
| cmp_result | input | 1 | True/false outcome of an ordered compare |
| csr_q | output | 32 | Register contents |
| round_to_zero | output | 1 | 1 selects round toward zero, 0 selects nearest-even |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle exception request |
| trap_code | output | 12 | Exception code, 0x120 while trap_req is high |
| cmp_bit | output | 1 | True/false bit written by ordered compares |

## Verification
Directed sequences first load all-ones and then sparse values. These separate the write mask from the rounding and flush decode. Operations are then issued with single conditions, with a condition that differs from the previous operation, and with no conditions. These separate flag replacement from cause accumulation. A trap scenario enables only invalid and then issues an inexact-only operation before and after an invalid one, which shows that a trap follows the accumulated cause and not the current flags. Compares with both orderings, and collisions between a write and an operation, finish the directed part. A long run of random inputs follows, compared each cycle against a behavioural model.

// File: rtl/fp_status_reg.sv
module fp_status_reg #(
  parameter logic [11:0] TRAP_CODE = 12'h120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        op_done,
  input  logic [4:0]  op_flags,
  input  logic        cmp_valid,
  input  logic        cmp_unordered,
  input  logic        cmp_result,
  output logic [31:0] csr_q,
  output logic        round_to_zero,
  output logic        flush_denorm,
  output logic        trap_req,
  output logic [11:0] trap_code,
  output logic        cmp_bit
);
  localparam int NCOND    = 5;
  localparam int RM_LO    = 0;
  localparam int FLAG_LO  = 2;
  localparam int EN_LO    = FLAG_LO + NCOND;
  localparam int CAUSE_LO = EN_LO + NCOND;
  localparam int DN_BIT   = CAUSE_LO + NCOND + 1;
  localparam logic [1:0]  RM_ZERO = 2'b01;
  localparam logic [31:0] WMASK   = (32'h1 << (CAUSE_LO + NCOND)) - 32'h1 | (32'h1 << DN_BIT);

  logic [NCOND-1:0] cause_nxt;
  logic             upd;

  assign upd       = op_done | (cmp_valid & cmp_unordered);
  assign cause_nxt = csr_q[CAUSE_LO +: NCOND] | op_flags;
  assign trap_code = trap_req ? TRAP_CODE : 12'h000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q         <= '0;
      round_to_zero <= 1'b0;
      flush_denorm  <= 1'b0;
      trap_req      <= 1'b0;
      cmp_bit       <= 1'b0;
    end else begin
      trap_req <= 1'b0;
      if (wr_en) begin
        csr_q         <= wr_data & WMASK;
        round_to_zero <= (wr_data[RM_LO +: 2] == RM_ZERO);
        flush_denorm  <= wr_data[DN_BIT];
      end else if (upd) begin
        csr_q[FLAG_LO +: NCOND]  <= op_flags;
        csr_q[CAUSE_LO +: NCOND] <= cause_nxt;
        trap_req <= (|op_flags) & (|(cause_nxt & csr_q[EN_LO +: NCOND]));
      end
      if (cmp_valid && !cmp_unordered)
        cmp_bit <= cmp_result;
    end
  end
endmodule

// File: rtl/fp_status_reg_chk.sv
module fp_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        op_done,
  input logic [4:0]  op_flags,
  input logic        cmp_valid,
  input logic        cmp_unordered,
  input logic        csr_q_unused_guard,
  input logic [31:0] csr_q,
  input logic        round_to_zero,
  input logic        flush_denorm,
  input logic        trap_req,
  input logic        cmp_bit
);
  logic ev;
  assign ev = (op_done | (cmp_valid & cmp_unordered)) & !wr_en;

  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> csr_q == ($past(wr_data) & 32'h0005FFFF)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !trap_req); // R10
  AST_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && op_flags == 5'd0) |=> (csr_q[6:2] == 5'd0 && csr_q[16:12] == $past(csr_q[16:12]) && !trap_req)); // R8
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> ((csr_q[16:12] & $past(csr_q[16:12])) == $past(csr_q[16:12]))); // R6
  AST_TRAP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ((csr_q[16:12] & csr_q[11:7]) != 5'd0)); // R7
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(round_to_zero) && $stable(flush_denorm))); // R11
  AST_UNORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_unordered) |=> $stable(cmp_bit)); // R9
endmodule

bind fp_status_reg fp_status_reg_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .op_done(op_done), .op_flags(op_flags), .cmp_valid(cmp_valid),
  .cmp_unordered(cmp_unordered), .csr_q_unused_guard(1'b0), .csr_q(csr_q),
  .round_to_zero(round_to_zero), .flush_denorm(flush_denorm),
  .trap_req(trap_req), .cmp_bit(cmp_bit)
);

// File: tb/fp_status_reg_test.sv
`timescale 1ns/1ps
module fp_status_reg_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, op_done = 0, cmp_valid = 0, cmp_unordered = 0, cmp_result = 0;
  logic [31:0] wr_data = 0;
  logic [4:0] op_flags = 0;
  logic [31:0] csr_q;
  logic round_to_zero, flush_denorm, trap_req, cmp_bit;
  logic [11:0] trap_code;

  int tests = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  logic [31:0] m_csr = 0;
  logic m_rtz = 0, m_fl = 0, m_trap = 0, m_t = 0;

  fp_status_reg uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_csr = 0; m_rtz = 0; m_fl = 0; m_trap = 0; m_t = 0;
    end else begin
      int newc;
      m_trap = 0;
      if (wr_en) begin
        m_csr = wr_data & 32'h0005FFFF;
        m_rtz = (wr_data % 4) == 1;
        m_fl  = (wr_data >> 18) % 2 == 1;
      end else if (op_done || (cmp_valid && cmp_unordered)) begin
        newc = int'(m_csr[16:12]) | int'(op_flags);
        m_trap = (op_flags != 0) && ((newc & int'(m_csr[11:7])) != 0);
        m_csr = (m_csr & ~32'h0001F07C) | (32'(op_flags) << 2) | (32'(newc) << 12);
      end
      if (cmp_valid && !cmp_unordered) m_t = cmp_result;
    end
  end

  task automatic chk32(string t, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk32({tag, " csr"}, csr_q, m_csr);
      chk32({tag, " ctrl"}, {28'd0, round_to_zero, flush_denorm, trap_req, cmp_bit},
            {28'd0, m_rtz, m_fl, m_trap, m_t});
      chk32({tag, " code"}, {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
    end
  end

  task automatic cyc(string t, logic w, logic [31:0] d, logic op, logic [4:0] f,
                     logic cv, logic cu, logic cr);
    @(negedge clk);
    tag = t; wr_en = w; wr_data = d; op_done = op; op_flags = f;
    cmp_valid = cv; cmp_unordered = cu; cmp_result = cr;
  endtask

  task automatic idle(string t);
    cyc(t, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic settle;
    @(posedge clk); #7;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle;
    chk32("R1 reset csr", csr_q, 32'h0);
    chk32("R1 reset trap", {31'd0, trap_req}, 32'h0);

    cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); settle;
    chk32("R2 masked write", csr_q, 32'h0005FFFF);
    chk32("R4 flush set", {31'd0, flush_denorm}, 32'h1);
    chk32("R3 rm 11 nearest", {31'd0, round_to_zero}, 32'h0);
    cyc("R3", 1, 32'h0000_0001, 0, 0, 0, 0, 0); settle;
    chk32("R3 rm 01 to zero", {31'd0, round_to_zero}, 32'h1);
    chk32("R4 flush clear", {31'd0, flush_denorm}, 32'h0);
    cyc("R3", 1, 32'h0000_0002, 0, 0, 0, 0, 0);
    cyc("R11", 0, 0, 1, 5'b11111, 0, 0, 0); settle;
    chk32("R11 rm unchanged by op", {31'd0, round_to_zero}, 32'h0);
    cyc("R2", 1, 32'h0000_0000, 0, 0, 0, 0, 0);

    cyc("R5", 0, 0, 1, 5'b00001, 0, 0, 0); settle;
    chk32("R5 inexact flag", csr_q, 32'h0000_1004);
    cyc("R5", 0, 0, 1, 5'b10000, 0, 0, 0); settle;
    chk32("R6 cause accumulates", csr_q, 32'h0001_1040);
    cyc("R8", 0, 0, 1, 5'b00000, 0, 0, 0); settle;
    chk32("R8 empty op keeps cause", csr_q, 32'h0001_1000);

    cyc("R7", 1, 32'h0000_0800, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 1, 5'b00001, 0, 0, 0); settle;
    chk32("R7 inexact not enabled", {31'd0, trap_req}, 32'h0);
    cyc("R7", 0, 0, 1, 5'b10000, 0, 0, 0); settle;
    chk32("R7 invalid traps", {20'd0, trap_code}, 32'h120);
    cyc("R7", 0, 0, 1, 5'b00001, 0, 0, 0); settle;
    chk32("R7 sticky cause traps", {31'd0, trap_req}, 32'h1);
    cyc("R8", 0, 0, 1, 5'b00000, 0, 0, 0); settle;
    chk32("R8 no flags no trap", {31'd0, trap_req}, 32'h0);

    cyc("R9", 0, 0, 0, 0, 1, 0, 1); settle;
    chk32("R9 ordered writes bit", {31'd0, cmp_bit}, 32'h1);
    cyc("R9", 0, 0, 0, 5'b10000, 1, 1, 0); settle;
    chk32("R9 unordered keeps bit", {31'd0, cmp_bit}, 32'h1);
    chk32("R9 unordered updates flags", csr_q[6:2], 32'h10);

    cyc("R10", 1, 32'h0000_0F80, 1, 5'b11111, 0, 0, 0); settle;
    chk32("R10 write wins", csr_q, 32'h0000_0F80);
    chk32("R10 no trap", {31'd0, trap_req}, 32'h0);
    idle("R10");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("random", r[0] & r[1] & r[2], $urandom, r[3], r[8:4], r[9], r[10], r[11]);
    end
    idle("random");
    repeat (2) @(posedge clk);
    #8;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule